// File: doc/BRIEF.md
# BCD Timekeeping Core with Minute/Hour/Day Alarm

This block keeps wall-clock time from a one-second strobe. Seconds, minutes and hours are held as two-digit BCD values in 24-hour form. Whole days are held as a plain binary count, 15 bits wide by default, that software reaches as two byte registers. A host reads and writes a small byte-wide register bank. The bank holds the running time, an alarm time of minute, hour and day, and one control byte.

Each accepted strobe starts a fixed sequence. The sequence steps seconds, then minutes, then hours, then days, passing the carry from one field to the next. It then compares the new time against the alarm. During this sequence a busy bit in the control byte reads 1. Host writes that arrive while busy is set are held back and applied once the sequence is over. The alarm matches on any chosen mix of minute, hour and day, and only on the strobe that brings seconds to 00. A match sets a sticky flag, and the flag drives the interrupt output when the interrupt is enabled.

Top module: `caltime_core`

## Requirements
- R1: After reset every register reads 0x00 and `alarm_irq` is low. This leaves the calendar stopped.
- R2: Seconds and minutes count BCD 0x00..0x59 and hours count BCD 0x00..0x23. A field steps only when every lower field wraps on the same strobe, and a digit 9 carries into the tens nibble (0x09 becomes 0x10).
- R3: The day count is binary. It steps when hours wrap from 0x23 and it wraps from 0x7FFF to 0. Bits 7..0 are at address 4 and bits 14..8 are at address 5, whose bit 7 reads 0.
- R4: A `sec_tick` pulse is ignored while the run bit (control bit 0) is 0.
- R5: A strobe accepted with run=1 makes control bit 7 (busy) read 1 for exactly five cycles, beginning the cycle after the strobe. A strobe that arrives while busy is ignored.
- R6: A write presented while busy leaves the registers unchanged until busy clears. Only the last such write is kept, and it is applied in the first non-busy cycle.
- R7: The alarm flag (control bit 2) sets at the end of a strobe sequence only when all of the following hold: the new seconds value is 0x00, at least one of the minute, hour and day enables (control bits 3, 4, 5) is set, and every enabled field equals its alarm register.
- R8: The alarm flag stays set until a control write with bit 2 = 1 clears it. A control write with bit 2 = 0 leaves it set.
- R9: `alarm_irq` is high exactly when the alarm flag and the interrupt enable (control bit 1) are both 1.
- R10: The address map is: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day low, 5 day high, 6 alarm minute, 7 alarm hour, 8 alarm day low, 9 alarm day high. Control bit 6 and the busy bit ignore writes. Addresses 10..15 read 0x00 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse marking the passing of one second |
| reg_wr | input | 1 | Write strobe for the register bank |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data for `rd_addr` |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest situation to reach from the ports is a host write that lands inside the five-cycle carry window. Reaching it needs the write strobe placed a known number of cycles after a strobe. The bench drives this window on purpose. It writes twice to seconds during busy, reads seconds while the window is still open to show the old value ticking, and then confirms the later write wins once busy drops. A second strobe is also placed inside the window to show it is dropped. Full roll-over from 23:59:59 at day 0x7FFF, and an alarm that fires only on that roll-over, are loaded directly. Random writes biased toward 59 and 23 then cover the carry paths.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

   // register addresses
   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_SEC  = 1;
   localparam int unsigned A_MIN  = 2;
   localparam int unsigned A_HR   = 3;
   localparam int unsigned A_DAYL = 4;
   localparam int unsigned A_DAYH = 5;
   localparam int unsigned A_AMIN = 6;
   localparam int unsigned A_AHR  = 7;
   localparam int unsigned A_ADYL = 8;
   localparam int unsigned A_ADYH = 9;

   // control byte bit positions
   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_IE   = 1;
   localparam int unsigned B_FLAG = 2;
   localparam int unsigned B_MEN  = 3;
   localparam int unsigned B_HEN  = 4;
   localparam int unsigned B_DEN  = 5;
   localparam int unsigned B_BUSY = 7;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SEC  = 3'd1,
      ST_MIN  = 3'd2,
      ST_HR   = 3'd3,
      ST_DAY  = 3'd4,
      ST_CMP  = 3'd5
   } step_e;

   function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top);
      if (v == top)
         return 8'h00;
      if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

endpackage

// File: rtl/caltime_bcd_field.sv
module caltime_bcd_field
   import caltime_pkg::*;
#(
   parameter logic [7:0] TOP = 8'h59
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] ld_val,
   input  logic       step,
   output logic [7:0] val,
   output logic       at_top
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val <= 8'h00;
      else if (load)
         val <= ld_val;
      else if (step)
         val <= bcd_next(val, TOP);
   end

   assign at_top = (val == TOP);

endmodule

// File: rtl/caltime_day_ctr.sv
module caltime_day_ctr #(
   parameter int unsigned W = 15
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_lo,
   input  logic         ld_hi,
   input  logic [7:0]   lo_val,
   input  logic [W-9:0] hi_val,
   input  logic         step,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld_lo)
         cnt[7:0] <= lo_val;
      else if (ld_hi)
         cnt[W-1:8] <= hi_val;
      else if (step)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/caltime_alarm_match.sv
module caltime_alarm_match #(
   parameter int unsigned W = 15
)(
   input  logic [7:0]   sec,
   input  logic [7:0]   min,
   input  logic [7:0]   hr,
   input  logic [W-1:0] day,
   input  logic [7:0]   a_min,
   input  logic [7:0]   a_hr,
   input  logic [W-1:0] a_day,
   input  logic         en_min,
   input  logic         en_hr,
   input  logic         en_day,
   output logic         hit
);

   logic any_en, ok_min, ok_hr, ok_day;

   assign any_en = en_min | en_hr | en_day;
   assign ok_min = !en_min || (min == a_min);
   assign ok_hr  = !en_hr  || (hr  == a_hr);
   assign ok_day = !en_day || (day == a_day);
   assign hit    = (sec == 8'h00) && any_en && ok_min && ok_hr && ok_day;

endmodule

// File: rtl/caltime_core.sv
module caltime_core
   import caltime_pkg::*;
#(
   parameter int unsigned DAY_W        = 15,
   parameter int unsigned ADDR_W       = 4,
   parameter bit          DEFER_WRITES = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              alarm_irq
);

   localparam int unsigned HI_W   = DAY_W - 8;
   localparam int unsigned NFIELD = 3;

   if (DAY_W < 9 || DAY_W > 16) begin : g_bad_day_w
      $error("caltime_core: DAY_W must lie in 9..16");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("caltime_core: ADDR_W must be at least 4");
   end

   step_e stg;
   logic  busy, carry_q, cmp_stage;
   logic  run_q, ie_q, flag_q, men_q, hen_q, den_q;
   logic [7:0]       amin_q, ahr_q;
   logic [DAY_W-1:0] aday_q, day_q;
   logic             hit;

   // applied write (after deferral)
   logic              ap_v;
   logic [ADDR_W-1:0] ap_addr;
   logic [7:0]        ap_data;

   assign busy      = (stg != ST_IDLE);
   assign cmp_stage = (stg == ST_CMP);

   // ---------------- carry sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= ST_IDLE;
      end else begin
         unique case (stg)
            ST_IDLE: if (sec_tick && run_q) stg <= ST_SEC;
            ST_SEC:  stg <= ST_MIN;
            ST_MIN:  stg <= ST_HR;
            ST_HR:   stg <= ST_DAY;
            ST_DAY:  stg <= ST_CMP;
            default: stg <= ST_IDLE;
         endcase
      end
   end

   // ---------------- write deferral ----------------
   if (DEFER_WRITES) begin : g_defer
      logic              pv;
      logic [ADDR_W-1:0] pa;
      logic [7:0]        pd;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pv <= 1'b0;
            pa <= '0;
            pd <= '0;
         end else if (busy) begin
            if (reg_wr) begin
               pv <= 1'b1;
               pa <= wr_addr;
               pd <= wr_data;
            end
         end else if (pv) begin
            pv <= reg_wr;
            if (reg_wr) begin
               pa <= wr_addr;
               pd <= wr_data;
            end
         end
      end

      assign ap_v    = !busy && (pv || reg_wr);
      assign ap_addr = pv ? pa : wr_addr;
      assign ap_data = pv ? pd : wr_data;
   end else begin : g_drop
      assign ap_v    = !busy && reg_wr;
      assign ap_addr = wr_addr;
      assign ap_data = wr_data;
   end

   // ---------------- BCD fields: sec, min, hr ----------------
   logic [7:0]        fval [NFIELD];
   logic [NFIELD-1:0] ftop, fload, fstep;

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      assign fload[i] = ap_v && (ap_addr == ADDR_W'(A_SEC + i));
      assign fstep[i] = (stg == step_e'(i + 1)) && ((i == 0) || carry_q);

      caltime_bcd_field #(
         .TOP ((i == NFIELD - 1) ? 8'h23 : 8'h59)
      ) u_fld (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (fload[i]),
         .ld_val (ap_data),
         .step   (fstep[i]),
         .val    (fval[i]),
         .at_top (ftop[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         carry_q <= 1'b0;
      else if (stg == ST_SEC)
         carry_q <= ftop[0];
      else if (stg == ST_MIN)
         carry_q <= carry_q & ftop[1];
      else if (stg == ST_HR)
         carry_q <= carry_q & ftop[2];
   end

   // ---------------- day counter ----------------
   caltime_day_ctr #(.W(DAY_W)) u_day (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_lo  (ap_v && (ap_addr == ADDR_W'(A_DAYL))),
      .ld_hi  (ap_v && (ap_addr == ADDR_W'(A_DAYH))),
      .lo_val (ap_data),
      .hi_val (ap_data[HI_W-1:0]),
      .step   ((stg == ST_DAY) && carry_q),
      .cnt    (day_q)
   );

   // ---------------- alarm and control registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
         men_q  <= 1'b0;
         hen_q  <= 1'b0;
         den_q  <= 1'b0;
         amin_q <= '0;
         ahr_q  <= '0;
         aday_q <= '0;
      end else begin
         if (cmp_stage && hit)
            flag_q <= 1'b1;
         if (ap_v) begin
            if (ap_addr == ADDR_W'(A_CTRL)) begin
               run_q <= ap_data[B_RUN];
               ie_q  <= ap_data[B_IE];
               men_q <= ap_data[B_MEN];
               hen_q <= ap_data[B_HEN];
               den_q <= ap_data[B_DEN];
               if (ap_data[B_FLAG])
                  flag_q <= 1'b0;
            end
            if (ap_addr == ADDR_W'(A_AMIN)) amin_q <= ap_data;
            if (ap_addr == ADDR_W'(A_AHR))  ahr_q  <= ap_data;
            if (ap_addr == ADDR_W'(A_ADYL)) aday_q[7:0] <= ap_data;
            if (ap_addr == ADDR_W'(A_ADYH)) aday_q[DAY_W-1:8] <= ap_data[HI_W-1:0];
         end
      end
   end

   caltime_alarm_match #(.W(DAY_W)) u_match (
      .sec    (fval[0]),
      .min    (fval[1]),
      .hr     (fval[2]),
      .day    (day_q),
      .a_min  (amin_q),
      .a_hr   (ahr_q),
      .a_day  (aday_q),
      .en_min (men_q),
      .en_hr  (hen_q),
      .en_day (den_q),
      .hit    (hit)
   );

   assign alarm_irq = flag_q & ie_q;

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = 8'h00;
      unique case (rd_addr)
         ADDR_W'(A_CTRL): begin
            rd_data[B_RUN]  = run_q;
            rd_data[B_IE]   = ie_q;
            rd_data[B_FLAG] = flag_q;
            rd_data[B_MEN]  = men_q;
            rd_data[B_HEN]  = hen_q;
            rd_data[B_DEN]  = den_q;
            rd_data[B_BUSY] = busy;
         end
         ADDR_W'(A_SEC):  rd_data = fval[0];
         ADDR_W'(A_MIN):  rd_data = fval[1];
         ADDR_W'(A_HR):   rd_data = fval[2];
         ADDR_W'(A_DAYL): rd_data = day_q[7:0];
         ADDR_W'(A_DAYH): rd_data[HI_W-1:0] = day_q[DAY_W-1:8];
         ADDR_W'(A_AMIN): rd_data = amin_q;
         ADDR_W'(A_AHR):  rd_data = ahr_q;
         ADDR_W'(A_ADYL): rd_data = aday_q[7:0];
         ADDR_W'(A_ADYH): rd_data[HI_W-1:0] = aday_q[DAY_W-1:8];
         default:         rd_data = 8'h00;
      endcase
   end

endmodule

// File: rtl/caltime_core_chk.sv
module caltime_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sec_tick,
   input logic       run,
   input logic       busy,
   input logic       cmp,
   input logic       ap_v,
   input logic       flag,
   input logic       ie,
   input logic       alarm_irq,
   input logic [7:0] sec
);

   logic [2:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_len <= 3'd0;
      else if (busy)
         run_len <= run_len + 3'd1;
      else
         run_len <= 3'd0;
   end

   AST_TICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && run && !busy) |=> busy); // R5

   AST_BUSY_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == 3'd5)); // R5

   AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ap_v) |=> $stable(sec)); // R6

   AST_FLAG_AT_SEC0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (sec == 8'h00)); // R7

   AST_FLAG_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(cmp)); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ap_v) |=> flag); // R8

   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> ie); // R9

   AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && ie) |-> alarm_irq); // R9

endmodule

bind caltime_core caltime_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .run       (run_q),
   .busy      (busy),
   .cmp       (cmp_stage),
   .ap_v      (ap_v),
   .flag      (flag_q),
   .ie        (ie_q),
   .alarm_irq (alarm_irq),
   .sec       (fval[0])
);

// File: tb/caltime_core_test.sv
`timescale 1ns/100ps
module caltime_core_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       alarm_irq;

   caltime_core uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .reg_wr    (reg_wr),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .alarm_irq (alarm_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // reference model
   logic [7:0]  m_sec, m_min, m_hr, m_am, m_ah;
   logic [14:0] m_day, m_ad;
   logic        m_run, m_ie, m_flag, m_men, m_hen, m_den;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int from_bcd(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] to_bcd(input int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   task automatic m_reset();
      m_sec = 0; m_min = 0; m_hr = 0; m_am = 0; m_ah = 0;
      m_day = 0; m_ad = 0;
      m_run = 0; m_ie = 0; m_flag = 0; m_men = 0; m_hen = 0; m_den = 0;
   endtask

   task automatic m_write(input int a, input logic [7:0] d);
      case (a)
         0: begin
            m_run = d[0]; m_ie = d[1]; m_men = d[3]; m_hen = d[4]; m_den = d[5];
            if (d[2]) m_flag = 1'b0;
         end
         1: m_sec = d;
         2: m_min = d;
         3: m_hr  = d;
         4: m_day[7:0]  = d;
         5: m_day[14:8] = d[6:0];
         6: m_am = d;
         7: m_ah = d;
         8: m_ad[7:0]  = d;
         9: m_ad[14:8] = d[6:0];
         default: ;
      endcase
   endtask

   task automatic m_tick();
      bit c;
      if (!m_run) return;
      c = (from_bcd(m_sec) == 59);
      m_sec = c ? 8'h00 : to_bcd(from_bcd(m_sec) + 1);
      if (c) begin
         c = (from_bcd(m_min) == 59);
         m_min = c ? 8'h00 : to_bcd(from_bcd(m_min) + 1);
         if (c) begin
            c = (from_bcd(m_hr) == 23);
            m_hr = c ? 8'h00 : to_bcd(from_bcd(m_hr) + 1);
            if (c) m_day = m_day + 15'd1;
         end
      end
      if (m_sec == 8'h00 && (m_men || m_hen || m_den) &&
          (!m_men || m_min == m_am) && (!m_hen || m_hr == m_ah) &&
          (!m_den || m_day == m_ad))
         m_flag = 1'b1;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      rd_addr = 4'(a);
      #0.1;
      d = rd_data;
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      reg_wr = 1'b0;
      m_write(a, d);
   endtask

   task automatic do_tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      repeat (6) @(negedge clk);
      m_tick();
   endtask

   task automatic check_all(input string ctx);
      logic [7:0] d;
      rd(0, d); chk("R8", {ctx, " control"}, d, {2'b00, m_den, m_hen, m_men, m_flag, m_ie, m_run});
      rd(1, d); chk("R2", {ctx, " seconds"}, d, m_sec);
      rd(2, d); chk("R2", {ctx, " minutes"}, d, m_min);
      rd(3, d); chk("R2", {ctx, " hours"}, d, m_hr);
      rd(4, d); chk("R3", {ctx, " day low"}, d, m_day[7:0]);
      rd(5, d); chk("R3", {ctx, " day high"}, d, {1'b0, m_day[14:8]});
      rd(6, d); chk("R10", {ctx, " alarm minute"}, d, m_am);
      rd(7, d); chk("R10", {ctx, " alarm hour"}, d, m_ah);
      rd(8, d); chk("R10", {ctx, " alarm day low"}, d, m_ad[7:0]);
      rd(9, d); chk("R10", {ctx, " alarm day high"}, d, {1'b0, m_ad[14:8]});
      chk("R9", {ctx, " irq"}, alarm_irq, m_flag & m_ie);
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
      wr(3, h); wr(2, mi); wr(1, s);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      m_reset();
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_all("R1 reset");
      rd(0, d); chk("R1", "busy after reset", d[7], 0);

      // R4: strobe ignored when stopped
      do_tick();
      rd(1, d); chk("R4", "seconds with run=0", d, 8'h00);
      check_all("R4 stopped");

      // R2: carries
      wr(0, 8'h01);
      set_time(8'h00, 8'h00, 8'h58);
      do_tick(); check_all("R2 58->59");
      do_tick(); check_all("R2 minute carry");
      set_time(8'h09, 8'h59, 8'h59);
      do_tick();
      rd(3, d); chk("R2", "hour 09->10", d, 8'h10);
      check_all("R2 hour carry");

      // R3: day wrap and high byte width
      wr(4, 8'hFF); wr(5, 8'hFF);
      rd(5, d); chk("R3", "day high bit7 reads 0", d, 8'h7F);
      set_time(8'h23, 8'h59, 8'h59);
      do_tick();
      rd(4, d); chk("R3", "day low after wrap", d, 8'h00);
      rd(5, d); chk("R3", "day high after wrap", d, 8'h00);
      check_all("R3 full rollover");

      // R5: busy window and strobe dropped while busy
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      rd(0, d); chk("R5", "busy first cycle", d[7], 1);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      repeat (2) @(negedge clk);
      rd(0, d); chk("R5", "busy fifth cycle", d[7], 1);
      @(negedge clk);
      rd(0, d); chk("R5", "busy cleared", d[7], 0);
      m_tick();
      check_all("R5 one step only");

      // R6: deferred writes, last one wins
      set_time(8'h04, 8'h20, 8'h10);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      reg_wr = 1'b1; wr_addr = 4'd1; wr_data = 8'h42;
      @(negedge clk); wr_data = 8'h17;
      @(negedge clk); reg_wr = 1'b0;
      rd(1, d); chk("R6", "seconds during busy", d, 8'h11);
      repeat (4) @(negedge clk);
      rd(1, d); chk("R6", "deferred write applied", d, 8'h17);
      m_tick(); m_sec = 8'h17;
      check_all("R6 after defer");

      // R7/R8/R9: alarm on minute+hour
      wr(6, 8'h05); wr(7, 8'h10); wr(8, 8'h05); wr(9, 8'h00);
      wr(0, 8'h1B);
      set_time(8'h10, 8'h04, 8'h59);
      do_tick();
      rd(0, d); chk("R7", "flag on match", d[2], 1);
      chk("R9", "irq with ie", alarm_irq, 1);
      check_all("R7 fire");
      do_tick();
      rd(0, d); chk("R8", "flag sticky across strobe", d[2], 1);
      wr(0, 8'h1B);
      rd(0, d); chk("R8", "write 0 keeps flag", d[2], 1);
      wr(0, 8'h19);
      chk("R9", "irq masked by ie=0", alarm_irq, 0);
      wr(0, 8'h1D);
      rd(0, d); chk("R8", "write 1 clears flag", d[2], 0);
      check_all("R8 cleared");

      // R7: day enable mismatch, no enables, seconds not 00
      wr(8, 8'h06); wr(0, 8'h3B);
      set_time(8'h10, 8'h04, 8'h59);
      do_tick();
      rd(0, d); chk("R7", "day mismatch no fire", d[2], 0);
      wr(0, 8'h03);
      set_time(8'h10, 8'h04, 8'h59);
      do_tick();
      rd(0, d); chk("R7", "no enables no fire", d[2], 0);
      wr(0, 8'h1B);
      set_time(8'h10, 8'h05, 8'h00);
      do_tick();
      rd(0, d); chk("R7", "seconds 01 no fire", d[2], 0);
      // alarm only on midnight rollover into day 1
      wr(6, 8'h00); wr(7, 8'h00); wr(8, 8'h01); wr(9, 8'h00);
      wr(4, 8'h00); wr(5, 8'h00);
      wr(0, 8'h3B);
      set_time(8'h23, 8'h59, 8'h59);
      do_tick();
      rd(0, d); chk("R7", "fire on day rollover", d[2], 1);
      check_all("R7 rollover");
      wr(0, 8'h07);

      // R10: unmapped address
      wr(12, 8'h55);
      rd(12, d); chk("R10", "unmapped reads 0", d, 8'h00);
      rd(15, d); chk("R10", "top address reads 0", d, 8'h00);
      check_all("R10 unmapped write");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op <= 3) begin
            do_tick();
         end else if (op <= 8) begin
            int a;
            logic [7:0] v;
            a = $urandom_range(0, 11);
            v = 8'($urandom);
            case (a)
               0: v[0] = ($urandom_range(0, 7) != 0);
               1, 2, 6: v = ($urandom_range(0, 3) == 0) ? 8'h59 : to_bcd($urandom_range(0, 59));
               3, 7: v = ($urandom_range(0, 3) == 0) ? 8'h23 : to_bcd($urandom_range(0, 23));
               default: ;
            endcase
            wr(a, v);
         end else begin
            @(negedge clk);
         end
         check_all("R2 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule